// File: doc/BRIEF.md
# Edge-Triggered Counter Capture with Glitch Filter

This block watches one asynchronous input line and, when a chosen transition appears on it, copies the current value of an external free-running counter into a capture register. The copy also sets a capture flag. An interrupt request is raised while that flag is set and the interrupt enable is on. Software picks the transition direction, enables or disables a glitch filter, and clears the flag, all through a small write port. Picking the direction lets software measure pulse widths and duty cycles by switching edges between captures.

The line first passes through a synchronizer chain. It then passes through an optional filter that only changes its output once a fixed number of consecutive system-clock samples agree on the new level. A separate mode input tells the block that the capture register is serving as the counter's period limit. In that mode no capture and no flag update take place. The counter, its prescaler and the interrupt controller are outside the block and appear only as ports.

Top module: `evt_capture`

## Requirements
- R1: After a synchronous reset, `cap_value` is 0, `cap_flag` is 0 and `irq` is 0. The edge select resets to falling, the filter to off and the interrupt enable to off.
- R2: With the filter off, an input transition applied before clock edge k loads `count_in` into `cap_value` at edge k+SYNC_STAGES. With the defaults the new value is visible three falling clock edges after the input change.
- R3: Bit 0 of the control register (address 0) selects the trigger: 1 means rising, 0 means falling. A transition in the other direction changes neither `cap_value` nor `cap_flag`.
- R4: With the filter on (control bit 1 = 1), the filtered level changes only after FILT_LEN consecutive system-clock samples of the synchronized input all show the new level. A pulse shorter than FILT_LEN cycles produces no capture.
- R5: Turning the filter on adds exactly FILT_LEN system-clock cycles of latency. This holds no matter how often `count_in` advances.
- R6: Each capture event overwrites `cap_value`, even if the flag from the previous capture is still set.
- R7: While `top_mode` is 1, capture is suppressed: `cap_value` holds and `cap_flag` does not become set.
- R8: Each capture sets `cap_flag`. Writing 1 to bit 0 of the status address (address 1) clears it. Writing 0 there leaves it unchanged.
- R9: If a capture event and a flag-clear write fall in the same cycle, `cap_flag` ends up set.
- R10: `irq` is 1 exactly when `cap_flag` is 1 and control bit 2 (interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous external event line |
| count_in | input | CNT_W | Current value of the external counter |
| top_mode | input | 1 | 1 while the capture register defines the counter period; blocks capture |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control, 1 = status (write-one-to-clear) |
| bus_wdata | input | 3 | Write data: control bits {irq_en, filt_en, rise_sel}, status bit 0 = clear |
| cap_value | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Capture interrupt request |

## Verification
The bench builds the block with CNT_W = 16, SYNC_STAGES = 2 and FILT_LEN = 4. With these values the capture latency can be measured exactly: 3 cycles with the filter off and 7 with it on. Glitches of one to three cycles then fall just under the filter's acceptance window. A behavioural model built on queues and run-length counting follows every cycle, including the slow-counter case where `count_in` advances only every fourth clock. Directed scenarios hit the same-cycle clear-versus-capture collision and the blocking effect of `top_mode`.

// File: rtl/evt_capture_pkg.sv
package evt_capture_pkg;

    localparam int CTRL_W        = 3;
    localparam int BIT_RISE      = 0;
    localparam int BIT_FILT      = 1;
    localparam int BIT_IRQ       = 2;
    localparam int BIT_FLAG_CLR  = 0;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_STAT = 1'b1
    } cap_addr_e;

    typedef struct packed {
        logic irq_en;
        logic filt_en;
        logic rise_sel;
    } cap_ctrl_t;

    function automatic cap_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] d);
        cap_ctrl_t c;
        c.irq_en   = d[BIT_IRQ];
        c.filt_en  = d[BIT_FILT];
        c.rise_sel = d[BIT_RISE];
        return c;
    endfunction

endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/evt_glitch_filter.sv
module evt_glitch_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int HIST_W = LEN - 1;

    logic [HIST_W-1:0] hist_q;
    logic [LEN-1:0]    window;
    logic              lvl_q;

    assign window = {hist_q, d};

    generate
        if (HIST_W == 1) begin : g_short
            always_ff @(posedge clk) begin
                if (rst) hist_q <= '0;
                else     hist_q <= d;
            end
        end else begin : g_long
            always_ff @(posedge clk) begin
                if (rst) hist_q <= '0;
                else     hist_q <= {hist_q[HIST_W-2:0], d};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)               lvl_q <= 1'b0;
        else if (&window)      lvl_q <= 1'b1;
        else if (~|window)     lvl_q <= 1'b0;
    end

    assign q = lvl_q;
endmodule

// File: rtl/evt_edge_detect.sv
module evt_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic rise_sel,
    output logic evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    always_comb begin
        if (rise_sel) evt = lvl & ~prev_q;
        else          evt = ~lvl & prev_q;
    end
endmodule

// File: rtl/evt_capture_regs.sv
module evt_capture_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             block,
    input  logic [CNT_W-1:0] count,
    input  logic             clr,
    output logic [CNT_W-1:0] cap_q,
    output logic             flag_q
);
    logic take;
    assign take = evt & ~block;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (take)      cap_q  <= count;
            if (take)      flag_q <= 1'b1;
            else if (clr)  flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_capture.sv
module evt_capture
    import evt_capture_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pin_in,
    input  logic [CNT_W-1:0]      count_in,
    input  logic                  top_mode,
    input  logic                  bus_we,
    input  logic                  bus_addr,
    input  logic [CTRL_W-1:0]     bus_wdata,
    output logic [CNT_W-1:0]      cap_value,
    output logic                  cap_flag,
    output logic                  irq
);
    cap_ctrl_t ctrl_q;
    logic      sync_lvl;
    logic      filt_lvl;
    logic      det_lvl;
    logic      cap_evt;
    logic      flag_clr;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (bus_we && cap_addr_e'(bus_addr) == ADDR_CTRL)
            ctrl_q <= unpack_ctrl(bus_wdata);
    end

    assign flag_clr = bus_we && (cap_addr_e'(bus_addr) == ADDR_STAT)
                      && bus_wdata[BIT_FLAG_CLR];

    evt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_lvl)
    );

    evt_glitch_filter #(.LEN(FILT_LEN)) u_filt (
        .clk (clk),
        .rst (rst),
        .d   (sync_lvl),
        .q   (filt_lvl)
    );

    assign det_lvl = ctrl_q.filt_en ? filt_lvl : sync_lvl;

    evt_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .lvl      (det_lvl),
        .rise_sel (ctrl_q.rise_sel),
        .evt      (cap_evt)
    );

    evt_capture_regs #(.CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .evt    (cap_evt),
        .block  (top_mode),
        .count  (count_in),
        .clr    (flag_clr),
        .cap_q  (cap_value),
        .flag_q (cap_flag)
    );

    assign irq = cap_flag & ctrl_q.irq_en;
endmodule

// File: rtl/evt_capture_chk.sv
module evt_capture_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             top_mode,
    input logic [CNT_W-1:0] count_in,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_flag,
    input logic             irq,
    input logic             evt,
    input logic             clr
);
    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (cap_value == '0 && !cap_flag && !irq));

    assert_overwrite_R6: assert property (@(posedge clk) disable iff (rst)
        (evt && !top_mode) |=> (cap_value == $past(count_in)));

    assert_top_hold_R7: assert property (@(posedge clk) disable iff (rst)
        top_mode |=> $stable(cap_value));

    assert_top_noflag_R7: assert property (@(posedge clk) disable iff (rst)
        (top_mode && !cap_flag) |=> !cap_flag);

    assert_flag_src_R8: assert property (@(posedge clk) disable iff (rst)
        (!evt && !cap_flag) |=> !cap_flag);

    assert_collide_R9: assert property (@(posedge clk) disable iff (rst)
        (evt && !top_mode && clr) |=> cap_flag);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> cap_flag);
endmodule

bind evt_capture evt_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .top_mode  (top_mode),
    .count_in  (count_in),
    .cap_value (cap_value),
    .cap_flag  (cap_flag),
    .irq       (irq),
    .evt       (cap_evt),
    .clr       (flag_clr)
);

// File: tb/evt_capture_bench.sv
`timescale 1ns/1ps
module evt_capture_bench;
    localparam int CNT_W = 16;
    localparam int SYNC  = 2;
    localparam int FILT  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pin_in = 1'b0;
    logic [CNT_W-1:0] count_in = '0;
    logic             top_mode = 1'b0;
    logic             bus_we = 1'b0;
    logic             bus_addr = 1'b0;
    logic [2:0]       bus_wdata = '0;
    logic [CNT_W-1:0] cap_value;
    logic             cap_flag;
    logic             irq;

    int total = 0;
    int bad   = 0;
    int cnt_div = 1;
    string phase = "R1";

    always #5 clk = ~clk;

    evt_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC), .FILT_LEN(FILT)) u_evt_capture (
        .clk(clk), .rst(rst), .pin_in(pin_in), .count_in(count_in),
        .top_mode(top_mode), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cap_value(cap_value), .cap_flag(cap_flag), .irq(irq)
    );

    // behavioural reference model
    int sq[$];
    int m_filt, m_prev, m_run, m_cap, m_flag;
    int m_rise, m_fen, m_ien;

    task automatic model_reset();
        sq.delete();
        for (int i = 0; i < SYNC; i++) sq.push_back(0);
        m_filt = 0; m_prev = 0; m_run = FILT; m_cap = 0; m_flag = 0;
        m_rise = 0; m_fen = 0; m_ien = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            int s_out, sel, ev, nxt;
            s_out = sq[SYNC-1];
            sel = m_fen ? m_filt : s_out;
            ev = (sel != m_prev) && (sel == m_rise);
            if (ev && !top_mode) begin
                m_cap = int'(count_in);
                m_flag = 1;
            end else if (bus_we && bus_addr && bus_wdata[0]) begin
                m_flag = 0;
            end
            m_prev = sel;
            if (m_run >= FILT) m_filt = s_out;
            sq.push_front(int'(pin_in));
            void'(sq.pop_back());
            nxt = sq[SYNC-1];
            if (nxt == s_out) m_run = m_run + 1; else m_run = 1;
            if (m_run > FILT) m_run = FILT;
            if (bus_we && !bus_addr) begin
                m_rise = int'(bus_wdata[0]);
                m_fen  = int'(bus_wdata[1]);
                m_ien  = int'(bus_wdata[2]);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk({phase, " cap"}, int'(cap_value), m_cap);
            chk({phase, " flag"}, int'(cap_flag), m_flag);
            chk({phase, " irq (R10)"}, int'(irq), m_flag & m_ien);
        end
    end

    // counter driven on falling edges, optionally divided
    int div_ctr = 0;
    always @(negedge clk) begin
        div_ctr++;
        if (div_ctr >= cnt_div) begin
            div_ctr = 0;
            count_in <= count_in + 16'd1;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic a, logic [2:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic measure(logic lvl, output int n);
        @(negedge clk);
        pin_in = lvl;
        n = 0;
        while (!cap_flag && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        fork
            begin
                #1500000;
                bad++; total++;
                $display("FAIL watchdog act=running exp=done");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none
    end

    initial begin
        int n;
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cap reset", int'(cap_value), 0);
        chk("R1 flag reset", int'(cap_flag), 0);
        chk("R1 irq reset", int'(irq), 0);

        // R3: default falling select; rising edge ignored
        phase = "R3";
        pin_in = 1'b1; cyc(6);
        chk("R3 rising ignored", int'(cap_flag), 0);
        pin_in = 1'b0; cyc(6);
        chk("R3 falling captured", int'(cap_flag), 1);

        // R8: write 0 no effect, write 1 clears
        phase = "R8";
        wr(1'b1, 3'b000); cyc(1);
        chk("R8 write0 keeps flag", int'(cap_flag), 1);
        wr(1'b1, 3'b001); cyc(1);
        chk("R8 write1 clears", int'(cap_flag), 0);

        // R2: rising select, filter off, latency
        phase = "R2";
        wr(1'b0, 3'b101);
        measure(1'b1, n);
        chk("R2 unfiltered latency", n, SYNC + 1);
        chk("R10 irq with enable", int'(irq), 1);

        // R6: second capture overwrites unread value
        phase = "R6";
        pin_in = 1'b0; cyc(5);
        pin_in = 1'b1; cyc(5);
        chk("R6 flag still set", int'(cap_flag), 1);
        wr(1'b1, 3'b001);

        // R4: filter on, short glitches rejected
        phase = "R4";
        wr(1'b0, 3'b011);
        pin_in = 1'b0; cyc(10);
        wr(1'b1, 3'b001); cyc(1);
        for (int w = 1; w < FILT; w++) begin
            pin_in = 1'b1; cyc(w);
            pin_in = 1'b0; cyc(8);
            chk("R4 glitch rejected", int'(cap_flag), 0);
        end

        // R5: filtered latency with slow counter
        phase = "R5";
        cnt_div = 4;
        measure(1'b1, n);
        chk("R5 filtered latency", n, SYNC + 1 + FILT);
        cnt_div = 1;
        wr(1'b1, 3'b001);

        // R7: top_mode blocks capture
        phase = "R7";
        wr(1'b0, 3'b001);
        pin_in = 1'b0; cyc(6);
        wr(1'b1, 3'b001);
        top_mode = 1'b1;
        pin_in = 1'b1; cyc(8);
        chk("R7 no flag in top mode", int'(cap_flag), 0);
        top_mode = 1'b0;
        pin_in = 1'b0; cyc(6);

        // R9: capture and clear in the same cycle
        phase = "R9";
        @(negedge clk);
        pin_in = 1'b1;
        cyc(SYNC);
        bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 3'b001;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R9 flag survives clear", int'(cap_flag), 1);

        cyc(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule